// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block keeps the request, mask and in-service state of eight interrupt lines and decides, every clock, whether one of them should be presented to the processor and which one. Each line has a trigger-mode bit. In level mode the request follows the pin. In edge mode a request is latched on a rising pin and stays latched.

Priority is circular. A rotation base picks the line that currently holds the highest position, and the positions then run upward from it, modulo eight. The best unmasked request is compared with the best in-service line, and an interrupt is raised only when the request ranks strictly higher. On the master instance, an optional nested flag removes the cascade line from the in-service side of that comparison. The mask, in-service set and rotation base are loaded from their inputs every clock. The decision is registered, so it appears one cycle after the state it was computed from.

Top module: `irq_resolver`

## Requirements
- R1: In level mode (trig_mode bit = 1), a line's request is set while its pin is high and cleared once its pin is low.
- R2: In edge mode (trig_mode bit = 0), a request is set only when the pin goes from low to high. A later low on the pin does not clear the request.
- R3: Priority positions 0..7 map to line (position + rot_base) mod 8, and position 0 ranks highest. With rot_base = 0, line 2 beats line 6. With rot_base = 3, line 6 beats line 2.
- R4: When no unmasked request exists, irq_pend is 0.
- R5: A line whose mask_in bit is 1 never wins. A lower-ranked unmasked line is reported in its place.
- R6: An interrupt is raised only when the winning request's position is strictly better than the best in-service position. An equal or worse position gives irq_pend = 0.
- R7: irq_line gives the winning line number, (winning position + rot_base) mod 8.
- R8: With sfn_en = 1 on the master instance, in-service bit 2 (the cascade line) takes no part in the comparison of R6.
- R9: irq_pend and irq_line are registered. They reflect state captured at one clock edge only after the following edge, which makes two edges from an input change.
- R10: Synchronous reset clears the request, last-level, mask and in-service registers, the rotation base and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_pin | input | 8 | Interrupt request pins |
| trig_mode | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_in | input | 8 | Mask register value, 1 = line masked |
| isr_in | input | 8 | In-service register value |
| rot_base | input | 3 | Line holding priority position 0 |
| sfn_en | input | 1 | Special fully nested flag |
| irq_pend | output | 1 | An interrupt should be presented |
| irq_line | output | 3 | Winning line number, 0 when none |

## Verification
The bench drives the same pin pattern in level and in edge mode. A falling pin then tells apart a request that follows its pin from one that stays latched. Pairs of requests on lines 2 and 6 are tried under two rotation bases, so the result separates a rotated scan from a fixed lowest-bit scan. Masking either line of a pair shows whether the winner is taken from the candidate set or from the raw request register. In-service patterns place requests above, equal to and below the active line, and the cascade in-service bit is tested with the nested flag both off and on. These patterns separate a strict comparison from a non-strict one, and separate the cascade exclusion from the ordinary in-service check.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int NLINES       = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int LW          = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_pin,
  input  logic [NLINES-1:0] trig_mode,
  input  logic [NLINES-1:0] mask_in,
  input  logic [NLINES-1:0] isr_in,
  input  logic [LW-1:0]     rot_base,
  input  logic              sfn_en,
  output logic              irq_pend,
  output logic [LW-1:0]     irq_line
);
  localparam logic [LW:0] NONE = (LW+1)'(NLINES);

  logic [NLINES-1:0] irr, last_lvl, imr, isr;
  logic [LW-1:0]     rot;
  logic              sfn;

  function automatic logic [LW:0] best_pos(input logic [NLINES-1:0] v,
                                           input logic [LW-1:0] r);
    best_pos = NONE;
    for (int p = NLINES - 1; p >= 0; p--)
      if (v[LW'(LW'(p) + r)]) best_pos = (LW+1)'(p);
  endfunction

  logic [NLINES-1:0] cand, isr_cmp;
  logic [LW:0]       cand_pos, isr_pos;

  assign cand     = irr & ~imr;
  assign isr_cmp  = (IS_MASTER && sfn) ? (isr & ~(NLINES'(1) << CASCADE_LINE)) : isr;
  assign cand_pos = best_pos(cand, rot);
  assign isr_pos  = best_pos(isr_cmp, rot);

  always_ff @(posedge clk) begin
    if (rst) begin
      irr      <= '0;
      last_lvl <= '0;
      imr      <= '0;
      isr      <= '0;
      rot      <= '0;
      sfn      <= 1'b0;
    end else begin
      irr      <= (trig_mode & req_pin) | (~trig_mode & (irr | (req_pin & ~last_lvl)));
      last_lvl <= req_pin;
      imr      <= mask_in;
      isr      <= isr_in;
      rot      <= rot_base;
      sfn      <= sfn_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
      irq_line <= '0;
    end else if (cand_pos < isr_pos) begin
      irq_pend <= 1'b1;
      irq_line <= cand_pos[LW-1:0] + rot;
    end else begin
      irq_pend <= 1'b0;
      irq_line <= '0;
    end
  end
endmodule

module irq_resolver_chk #(
  parameter int NLINES = 8,
  localparam int LW    = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] req_pin,
  input logic [NLINES-1:0] trig_mode,
  input logic [NLINES-1:0] irr,
  input logic [NLINES-1:0] imr,
  input logic              irq_pend,
  input logic [LW-1:0]     irq_line
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      p_reset_clear_r10: assert (!irq_pend && irq_line == '0 && irr == '0)
        else $error("outputs or requests not cleared by reset");
    end
  end

  p_level_follow_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((irr ^ $past(req_pin)) & $past(trig_mode)) == '0));

  p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~$past(trig_mode) & $past(irr) & ~irr) == '0));

  p_unmasked_win_r5: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (($past(imr) & (NLINES'(1) << irq_line)) == '0));

  p_win_requested_r7: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (($past(irr) & (NLINES'(1) << irq_line)) != '0));

  p_none_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(irr & ~imr) == '0) |-> !irq_pend);
endmodule

bind irq_resolver irq_resolver_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst(rst), .req_pin(req_pin), .trig_mode(trig_mode),
  .irr(irr), .imr(imr), .irq_pend(irq_pend), .irq_line(irq_line)
);

// File: tb/irq_resolver_tb.sv
`timescale 1ns/100ps
module irq_resolver_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_pin, trig_mode, mask_in, isr_in;
  logic [2:0] rot_base;
  logic       sfn_en;
  logic       irq_pend;
  logic [2:0] irq_line;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_resolver u_dut (
    .clk(clk), .rst(rst), .req_pin(req_pin), .trig_mode(trig_mode),
    .mask_in(mask_in), .isr_in(isr_in), .rot_base(rot_base), .sfn_en(sfn_en),
    .irq_pend(irq_pend), .irq_line(irq_line)
  );

  task automatic check(input string tag, input logic p, input logic [2:0] l,
                       input logic ep, input logic [2:0] el);
    total++;
    if (p !== ep || (ep && l !== el)) begin
      bad++;
      $display("FAIL %s: pend=%0b line=%0d expected pend=%0b line=%0d", tag, p, l, ep, el);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_pin = '0; trig_mode = '0; mask_in = '0; isr_in = '0;
    rot_base = '0; sfn_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 reset state", irq_pend, irq_line, 1'b0, 3'd0);
    trig_mode = 8'h20; req_pin = 8'h20;
    settle();
    check("R10 pre-reset request", irq_pend, irq_line, 1'b1, 3'd5);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 reset clears output", irq_pend, irq_line, 1'b0, 3'd0);
    rst = 1'b0; req_pin = '0;
  endtask

  task automatic t_level();
    do_reset();
    trig_mode = 8'h20; req_pin = 8'h20;
    settle();
    check("R1 level high", irq_pend, irq_line, 1'b1, 3'd5);
    req_pin = '0;
    settle();
    check("R1 level low clears", irq_pend, irq_line, 1'b0, 3'd0);
  endtask

  task automatic t_edge();
    do_reset();
    trig_mode = 8'h00; req_pin = 8'h08;
    settle();
    check("R2 edge rise", irq_pend, irq_line, 1'b1, 3'd3);
    req_pin = '0;
    settle();
    check("R2 edge held after fall", irq_pend, irq_line, 1'b1, 3'd3);
  endtask

  task automatic t_timing();
    do_reset();
    trig_mode = 8'hFF;
    req_pin = 8'h02;
    @(posedge clk); @(negedge clk);
    check("R9 not yet after one edge", irq_pend, irq_line, 1'b0, 3'd0);
    @(posedge clk); @(negedge clk);
    check("R9 valid after two edges", irq_pend, irq_line, 1'b1, 3'd1);
  endtask

  task automatic t_rotate();
    do_reset();
    trig_mode = 8'hFF; req_pin = 8'h44;
    settle();
    check("R3 rot0 line2 wins", irq_pend, irq_line, 1'b1, 3'd2);
    rot_base = 3'd3;
    settle();
    check("R3 R7 rot3 line6 wins", irq_pend, irq_line, 1'b1, 3'd6);
    rot_base = 3'd7;
    settle();
    check("R7 rot7 line2 wins", irq_pend, irq_line, 1'b1, 3'd2);
  endtask

  task automatic t_mask();
    do_reset();
    trig_mode = 8'hFF; req_pin = 8'h44; mask_in = 8'h04;
    settle();
    check("R5 masked line2 skipped", irq_pend, irq_line, 1'b1, 3'd6);
    mask_in = 8'h44;
    settle();
    check("R4 all masked none", irq_pend, irq_line, 1'b0, 3'd0);
    req_pin = '0; mask_in = '0;
    settle();
    check("R4 no request none", irq_pend, irq_line, 1'b0, 3'd0);
  endtask

  task automatic t_inservice();
    do_reset();
    trig_mode = 8'hFF; isr_in = 8'h10; req_pin = 8'h40;
    settle();
    check("R6 lower request blocked", irq_pend, irq_line, 1'b0, 3'd0);
    req_pin = 8'h10;
    settle();
    check("R6 equal request blocked", irq_pend, irq_line, 1'b0, 3'd0);
    req_pin = 8'h42;
    settle();
    check("R6 higher request raised", irq_pend, irq_line, 1'b1, 3'd1);
    rot_base = 3'd5; req_pin = 8'h40;
    settle();
    check("R6 rotated higher request", irq_pend, irq_line, 1'b1, 3'd6);
  endtask

  task automatic t_nested();
    do_reset();
    trig_mode = 8'hFF; isr_in = 8'h04; req_pin = 8'h04;
    settle();
    check("R8 sfn off cascade blocked", irq_pend, irq_line, 1'b0, 3'd0);
    sfn_en = 1'b1;
    settle();
    check("R8 sfn on cascade raised", irq_pend, irq_line, 1'b1, 3'd2);
    req_pin = 8'h20;
    settle();
    check("R8 sfn on lower line raised", irq_pend, irq_line, 1'b1, 3'd5);
    isr_in = 8'h06;
    settle();
    check("R8 sfn keeps other isr", irq_pend, irq_line, 1'b0, 3'd0);
  endtask

  initial begin
    rst = 1'b1; req_pin = '0; trig_mode = '0; mask_in = '0; isr_in = '0;
    rot_base = '0; sfn_en = 1'b0;
    t_reset();
    t_level();
    t_edge();
    t_timing();
    t_rotate();
    t_mask();
    t_inservice();
    t_nested();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule